// File: doc/BRIEF.md
# I2C Byte-Memory Read Target

This block is an I2C target that sits in front of a small byte memory and answers reads from a bus master. It keeps one address pointer. After every byte it sends, the pointer moves to the next byte, and it wraps from the top address back to zero. Reads and pointer loads share this pointer, so it survives from one transaction to the next.

A master can read in three ways. A current-address read starts directly with a read request. A random read first sends a short write of only the byte address, then a repeated START and a read request. A sequential read keeps acknowledging each byte to stream through the array. Byte writes that store data are not supported. A write transaction only loads the pointer.

The bus lines are sampled with the system clock through two-flop synchronizers. The block pulls SDA low through a single registered output-enable. The memory size is a parameter of 256, 512, 1024 or 2048 bytes. For sizes above 256 bytes, the low bits of the 7-bit target address field pick the 256-byte page when the pointer is loaded.

Top module: `i2c_rd_target`

## Requirements
- R1: Out of reset the pointer is 0 and `sda_oe` is 0. The first current-address read returns the byte at address 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START in any state, including partway through a byte, restarts reception of the address byte. A STOP releases SDA and returns the block to idle.
- R3: The address byte holds the 7-bit target address in bits 7..1, MSB first, and the read flag in bit 0 (1 = read). The block compares the upper 7-P bits with `DEV_ADDR`, where P = log2(MEM_BYTES) - 8. On a mismatch it never drives SDA, and the pointer is left unchanged, until the next START.
- R4: For each byte it accepts (a matching address byte, or the byte address of a write), the block holds SDA low for the whole ninth clock.
- R5: After a matching read request, the block sends the byte at the pointer, MSB first. The pointer then moves to pointer+1.
- R6: In a write, the byte that follows the address byte loads the pointer. The lower 8 bits come from that byte and the upper P bits from bits P..1 of the address byte. No data is stored, and a later read begins at the loaded address, whether it follows a repeated START or a STOP.
- R7: A master ACK (SDA low on the ninth clock) after a sent byte makes the block send the next byte. A NACK makes it release SDA and wait for START or STOP.
- R8: The pointer advances over every address bit and wraps from MEM_BYTES-1 to 0, so a stream can run across the top of the array.
- R9: `sda_oe` changes only while SCL is low.
- R10: The byte stored at address a is (a*29 + (a>>8)*5 + 60) mod 256.
- R11: The pointer is kept between transactions. A current-address read that follows a transfer ending at address N returns the byte at N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
The reads are tried from the reset pointer, after a page-0 random load, after a page-1 load near the top of the array, after a load that ends in STOP, and straight after another transfer. Together these separate a pointer that only increments from one that loads, keeps its value and wraps. Streams of one and three bytes separate ACK-driven continuation from NACK release. A foreign address and a START cut into the middle of a byte address show that the pointer is left untouched and that reception restarts. A monitor watches every change of the enable against the level of SCL.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_EV,
    ST_ADDR_ACK,
    ST_BADR,
    ST_BADR_EV,
    ST_BADR_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_t;

  // Fixed content of the byte array (R10)
  function automatic logic [7:0] fill_byte(input int unsigned a);
    return 8'(a * 29 + (a >> 8) * 5 + 60);
  endfunction

endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
  parameter int           W    = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= INIT;
      q      <= INIT;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/i2c_rd_cond.sv
module i2c_rd_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] lines;
  logic       scl_p, sda_p;

  i2c_rd_sync #(.W(2), .INIT(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(lines)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= lines[1];
      sda_p <= lines[0];
    end
  end

  assign scl_lvl   = lines[1];
  assign sda_lvl   = lines[0];
  assign scl_rise  = lines[1] & ~scl_p;
  assign scl_fall  = ~lines[1] & scl_p;
  assign start_det = lines[1] & scl_p & sda_p & ~lines[0];
  assign stop_det  = lines[1] & scl_p & ~sda_p & lines[0];
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rd_data
);
  import i2c_rd_pkg::*;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int unsigned i = 0; i < DEPTH; i++) mem[i] = fill_byte(i);
  end

  always_ff @(posedge clk) rd_data <= mem[addr];
endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target #(
  parameter int         MEM_BYTES = 512,
  parameter logic [6:0] DEV_ADDR  = 7'h50
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import i2c_rd_pkg::*;

  localparam int         ADDR_W     = $clog2(MEM_BYTES);
  localparam int         HI_W       = ADDR_W - 8;
  localparam logic [6:0] MATCH_MASK = 7'(7'h7F << HI_W);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  tgt_state_t        state;
  logic [2:0]        cnt;
  logic [7:0]        rx_sh, tx_sh, rd_data;
  logic [6:0]        dev_q;
  logic              rw_q, mack;
  logic [ADDR_W-1:0] ptr, ptr_load;
  logic              addr_match;

  i2c_rd_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rd_mem #(.DEPTH(MEM_BYTES), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .addr(ptr), .rd_data(rd_data)
  );

  assign addr_match = ((rx_sh[7:1] ^ DEV_ADDR) & MATCH_MASK) == 7'd0;
  assign ptr_load   = ADDR_W'({dev_q, rx_sh});

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= 3'd0;
      rx_sh  <= 8'd0;
      tx_sh  <= 8'd0;
      dev_q  <= 7'd0;
      rw_q   <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= 3'd0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_BADR: if (scl_rise) begin
          rx_sh <= {rx_sh[6:0], sda_lvl};
          cnt   <= cnt + 3'd1;
          if (cnt == 3'd7) state <= (state == ST_ADDR) ? ST_ADDR_EV : ST_BADR_EV;
        end
        ST_ADDR_EV: if (scl_fall) begin
          if (addr_match) begin
            dev_q  <= rx_sh[7:1];
            rw_q   <= rx_sh[0];
            sda_oe <= 1'b1;
            state  <= ST_ADDR_ACK;
          end else begin
            state  <= ST_IDLE;
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          cnt <= 3'd0;
          if (rw_q) begin
            tx_sh  <= rd_data;
            sda_oe <= ~rd_data[7];
            state  <= ST_TX;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_BADR;
          end
        end
        ST_BADR_EV: if (scl_fall) begin
          ptr    <= ptr_load;
          sda_oe <= 1'b1;
          state  <= ST_BADR_ACK;
        end
        ST_BADR_ACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          state  <= ST_IDLE;
        end
        ST_TX: if (scl_fall) begin
          if (cnt == 3'd7) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + ADDR_W'(1);
            state  <= ST_TX_ACK;
          end else begin
            tx_sh  <= {tx_sh[6:0], 1'b0};
            sda_oe <= ~tx_sh[6];
            cnt    <= cnt + 3'd1;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack <= ~sda_lvl;
          if (scl_fall) begin
            if (mack) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
              cnt    <= 3'd0;
              state  <= ST_TX;
            end else begin
              state  <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: the enable only starts pulling while the sampled clock is low
  assert_oe_rise_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);

  // R2: a START puts the block back into address reception, line released
  assert_start_restarts_R2: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && cnt == 3'd0 && !sda_oe));

  // R2: a STOP releases the line
  assert_stop_releases_R2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && state == ST_IDLE));

  // R3: a foreign address leads to idle without acknowledge
  assert_mismatch_noack_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR_EV && scl_fall && !addr_match && !start_det && !stop_det)
      |=> (state == ST_IDLE && !sda_oe));

  // R5, R8: each finished byte moves the pointer by one, wrapping
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX_ACK && $past(state) == ST_TX) |-> ptr == $past(ptr) + ADDR_W'(1));

  // R6: the byte address lands in the pointer when it is acknowledged
  assert_ptr_load_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BADR_ACK && $past(state) == ST_BADR_EV) |-> (ptr == ptr_load && sda_oe));
endmodule

// File: tb/i2c_rd_target_bench.sv
module i2c_rd_target_bench;
  localparam int         MEM_BYTES = 512;
  localparam logic [6:0] DEV_ADDR  = 7'h50;
  localparam int         Q         = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_rd_target #(.MEM_BYTES(MEM_BYTES), .DEV_ADDR(DEV_ADDR)) u_i2c_rd_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int total = 0;
  int bad   = 0;
  int eptr  = 0;
  int viol  = 0;
  bit done  = 1'b0;

  typedef struct { logic [7:0] v; string req; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] obs_q[$];

  function automatic logic [7:0] ref_byte(input int a);
    int s;
    s = a * 29 + (a / 256) * 5 + 60;
    return 8'(s % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected and observed bytes in order and compares them
  always @(negedge clk) begin
    if (obs_q.size() > 0 && exp_q.size() > 0) begin
      exp_t       e;
      logic [7:0] o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      chk(o == e.v, e.req, o, e.v);
    end
  end

  // R9 watcher: enable must never move while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_oe != oe_prev && scl_m) viol++;
    oe_prev <= sda_oe;
  end

  task automatic start_c();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; tick(Q);
      scl_m = 1'b1;   tick(Q);
      scl_m = 1'b0;   tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q/2);
    ack = !sda_line;
    tick(Q/2);
    scl_m = 1'b0; tick(Q);
  endtask

  // driver: queue the expected byte, then clock one in and hand it to the monitor
  task automatic recv_byte(input bit give_ack, input string req, input logic [7:0] exp);
    logic [7:0] b;
    exp_t e;
    e.v = exp; e.req = req;
    exp_q.push_back(e);
    b = 8'd0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q/2);
      b = {b[6:0], sda_line};
      tick(Q/2);
      scl_m = 1'b0;
    end
    sda_m = !give_ack; tick(Q);
    scl_m = 1'b1;      tick(Q);
    scl_m = 1'b0;      tick(Q);
    sda_m = 1'b1;
    obs_q.push_back(b);
  endtask

  task automatic read_stream(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, req, ref_byte(eptr));
      eptr = (eptr + 1) % MEM_BYTES;
    end
  endtask

  task automatic expect_ack(input logic [7:0] b, input string req);
    bit a;
    send_byte(b, a);
    chk(a == 1'b1, req, a, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    tick(5);
    chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    rst = 1'b0;
    tick(5);
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);

    // R1, R5, R10: current-address read from the reset pointer
    start_c();
    expect_ack({DEV_ADDR, 1'b1}, "R4 read addr ack");
    read_stream(1, "R1 R5 first byte at 0");
    stop_c();

    // R6, R7: random read, page 0, three bytes streamed
    start_c();
    expect_ack({DEV_ADDR, 1'b0}, "R4 write addr ack");
    expect_ack(8'h10, "R4 byte address ack");
    eptr = 'h10;
    start_c();
    expect_ack({DEV_ADDR, 1'b1}, "R4 read addr ack after restart");
    read_stream(3, "R6 R7 random then sequential");
    tick(4);
    chk(sda_oe == 1'b0, "R7 released after NACK", sda_oe, 0);
    stop_c();

    // R11: current read continues after the last byte
    start_c();
    expect_ack({DEV_ADDR, 1'b1}, "R4 read addr ack");
    read_stream(1, "R11 continues at N+1");
    stop_c();

    // R6, R8: page bit from the address field, stream across the top
    start_c();
    expect_ack({DEV_ADDR | 7'h01, 1'b0}, "R4 page write addr ack");
    expect_ack(8'hFE, "R4 page byte address ack");
    eptr = 'h1FE;
    start_c();
    expect_ack({DEV_ADDR, 1'b1}, "R4 read addr ack");
    read_stream(3, "R8 wrap past top");
    stop_c();

    // R3: foreign address is ignored, pointer untouched
    start_c();
    send_byte(8'h46, a);
    chk(a == 1'b0, "R3 no ack on foreign address", a, 0);
    send_byte(8'h10, a);
    chk(a == 1'b0, "R3 still silent after mismatch", a, 0);
    stop_c();
    start_c();
    expect_ack({DEV_ADDR, 1'b1}, "R4 read addr ack");
    read_stream(1, "R3 pointer untouched by foreign access");
    stop_c();

    // R2: START in the middle of a byte address restarts reception
    start_c();
    expect_ack({DEV_ADDR, 1'b0}, "R4 write addr ack");
    send_bits(8'h55, 4);
    start_c();
    expect_ack({DEV_ADDR, 1'b0}, "R2 addr ack after mid-byte START");
    expect_ack(8'h20, "R2 byte address ack");
    eptr = 'h20;
    start_c();
    expect_ack({DEV_ADDR, 1'b1}, "R4 read addr ack");
    read_stream(1, "R2 read after restart");
    stop_c();

    // R6: pointer load closed with STOP, then plain read (page 0 and page 1)
    start_c();
    expect_ack({DEV_ADDR, 1'b0}, "R4 write addr ack");
    expect_ack(8'h77, "R4 byte address ack");
    stop_c();
    chk(sda_oe == 1'b0, "R2 released after STOP", sda_oe, 0);
    eptr = 'h77;
    start_c();
    expect_ack({DEV_ADDR, 1'b1}, "R4 read addr ack");
    read_stream(1, "R6 load then STOP then read");
    stop_c();

    start_c();
    expect_ack({DEV_ADDR | 7'h01, 1'b0}, "R4 page write addr ack");
    expect_ack(8'h05, "R4 byte address ack");
    stop_c();
    eptr = 'h105;
    start_c();
    expect_ack({DEV_ADDR, 1'b1}, "R4 read addr ack");
    read_stream(2, "R6 R10 page one contents");
    stop_c();

    while (exp_q.size() > 0 || obs_q.size() > 0) tick(1);
    chk(viol == 0, "R9 enable moved while SCL high", viol, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule